// File: doc/BRIEF.md
# Debounced Sticky Press Flag

This block observes one slow, asynchronous, active-high push-button line and raises a flag that stays set once a real press has been recognised. The raw line is first carried into the system clock domain by a two-flop synchronizer. After that, a run-length counter accepts the press only when the synchronized level has been high for `QUAL_CYCLES` back-to-back clock cycles. Any spike shorter than that window is discarded.

Acceptance is a one-way event. The flag is an ordinary edge-triggered register clocked by the free-running system clock, and only the active-low asynchronous reset brings it back to 0. On the same edge that the flag rises, the block also produces a single-cycle notification pulse. Downstream logic can therefore either poll the level or react to the pulse.

Top module: `btn_press_flag`

## Requirements
- R1: While `rst_n` is low, `press_seen` and `press_event` are 0, and all internal stages (both synchronizer flops, the run counter, the flag) are cleared regardless of `btn_raw`.
- R2: `btn_raw` reaches the qualification logic only after two synchronizer flops, so neither output can change on the first or second clock edge after `btn_raw` rises.
- R3: If `btn_raw` rises before edge 1 and stays high, `press_seen` becomes 1 on edge 2 + `QUAL_CYCLES` and not earlier.
- R4: The run counter restarts from zero on any cycle in which the synchronized level is low. Two runs of `QUAL_CYCLES`-1 high cycles separated by one low cycle do not set the flag.
- R5: A high pulse on `btn_raw` that lasts fewer than `QUAL_CYCLES` clock edges never sets `press_seen`. A pulse of exactly `QUAL_CYCLES` edges or longer does set it.
- R6: Once `press_seen` is 1 it stays 1 until reset, whatever `btn_raw` does afterwards.
- R7: `press_event` is high for exactly one cycle, on the same edge on which `press_seen` goes from 0 to 1.
- R8: After the first acceptance, later qualifying presses produce no further `press_event` until the next reset.
- R9: A reset applied part-way through a qualification run discards that progress. After reset is released, a held input needs the full 2 + `QUAL_CYCLES` edges again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_raw | input | 1 | Asynchronous button line, 1 while pressed |
| press_seen | output | 1 | Sticky flag, set once a qualified press is seen |
| press_event | output | 1 | One-cycle pulse on the edge the flag sets |

## Verification
Acceptance of a press and the notification pulse fall on the same clock edge. A fault that shifts either one by a cycle would go unnoticed if the two were checked separately. The bench provokes this coincidence by holding the input for exactly `QUAL_CYCLES` edges, and also for longer runs. After every edge it samples both outputs together and compares them with a run-length model. That model predicts the single edge on which both must change.

// File: rtl/btn_flag_pkg.sv
package btn_flag_pkg;

  // Bits needed to count 0 .. q-1 (at least one bit).
  function automatic int unsigned run_width(input int unsigned q);
    return (q < 2) ? 1 : $clog2(q);
  endfunction

  // Next run-length value: restart on low, saturate at q-1.
  function automatic int unsigned run_next(input logic lvl,
                                           input int unsigned cur,
                                           input int unsigned q);
    if (!lvl) return 0;
    if (cur >= q - 1) return q - 1;
    return cur + 1;
  endfunction

  // A press qualifies on the cycle that completes q consecutive highs.
  function automatic logic run_complete(input logic lvl,
                                        input int unsigned cur,
                                        input int unsigned q);
    return lvl && (cur >= q - 1);
  endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
        AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
          chain_q[i] == $past(chain_q[i-1])); // R2
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/btn_qualifier.sv
module btn_qualifier #(
  parameter int unsigned QUAL_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic accept
);
  localparam int unsigned CW    = btn_flag_pkg::run_width(QUAL_CYCLES);
  localparam int unsigned LIMIT = QUAL_CYCLES - 1;

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;

  always_comb begin
    run_d  = CW'(btn_flag_pkg::run_next(lvl, 32'(run_q), QUAL_CYCLES));
    accept = btn_flag_pkg::run_complete(lvl, 32'(run_q), QUAL_CYCLES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  AST_RUN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl |=> (run_q == '0)); // R4
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(run_q) <= LIMIT); // R4
endmodule

// File: rtl/btn_sticky.sv
module btn_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  output logic flag,
  output logic pulse
);
  logic flag_q, pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      flag_q  <= flag_q | accept;
      pulse_q <= accept & ~flag_q;
    end
  end

  assign flag  = flag_q;
  assign pulse = pulse_q;

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> flag_q); // R6
  AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (flag_q && !$past(flag_q))); // R7
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q); // R8
endmodule

// File: rtl/btn_press_flag.sv
module btn_press_flag #(
  parameter int unsigned QUAL_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_raw,
  output logic press_seen,
  output logic press_event
);
  logic sync_lvl;
  logic accept;

  btn_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(btn_raw), .sync_out(sync_lvl)
  );

  btn_qualifier #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk(clk), .rst_n(rst_n), .lvl(sync_lvl), .accept(accept)
  );

  btn_sticky u_flag (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .flag(press_seen), .pulse(press_event)
  );

  AST_RISE_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(press_seen) |-> $past(sync_lvl)); // R5
  AST_EVENT_MATCHES_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(press_seen) |-> press_event); // R7
endmodule

// File: tb/btn_press_flag_test.sv
module btn_press_flag_test;
  localparam int PERIOD = 10;
  localparam int QC     = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_raw = 1'b0;
  logic press_seen, press_event;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  btn_press_flag #(.QUAL_CYCLES(QC)) uut (
    .clk(clk), .rst_n(rst_n), .btn_raw(btn_raw),
    .press_seen(press_seen), .press_event(press_event)
  );

  task automatic check(input string tag, input logic act, input logic exp, input int edge_no);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s edge %0d: actual %b expected %b", tag, edge_no, act, exp);
    end
  endtask

  // Runs one episode: optional pre-reset progress, reset, then pattern bits
  // (bit e-1 drives btn_raw before edge e). Expectation from run lengths.
  task automatic episode(input string tag, input logic [63:0] pat, input int len, input int prefix);
    int runlen [0:63];
    logic exp_flag;
    logic cond;
    @(negedge clk);
    for (int p = 0; p < prefix; p++) begin
      btn_raw = 1'b1;
      @(negedge clk);
    end
    rst_n = 1'b0;
    @(negedge clk);
    check({tag, " R1 flag in reset"}, press_seen, 1'b0, 0);
    check({tag, " R1 event in reset"}, press_event, 1'b0, 0);
    rst_n = 1'b1;
    exp_flag = 1'b0;
    runlen[0] = 0;
    for (int e = 1; e <= len; e++) begin
      btn_raw = pat[e-1];
      @(posedge clk);
      @(negedge clk);
      runlen[e] = pat[e-1] ? runlen[e-1] + 1 : 0;
      cond = (e >= 3) && (runlen[e-2] >= QC);
      check({tag, " R3 R6 flag"}, press_seen, exp_flag | cond, e);
      check({tag, " R7 R8 event"}, press_event, cond & ~exp_flag, e);
      exp_flag = exp_flag | cond;
    end
    btn_raw = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R5 / R2 / R3: sweep pulse widths 1 .. QC+3
    for (int w = 1; w <= QC + 3; w++) begin
      logic [63:0] pat = '0;
      for (int b = 0; b < w; b++) pat[b] = 1'b1;
      episode("R5 R2 width sweep", pat, QC + 10, 0);
    end
    // R3: held input
    episode("R3 held", {64{1'b1}}, QC + 8, 0);
    // R4: two short runs separated by one low, then a full run
    begin
      logic [63:0] pat = '0;
      for (int b = 0; b < QC - 1; b++) pat[b] = 1'b1;
      for (int b = QC; b < 2*QC - 1; b++) pat[b] = 1'b1;
      episode("R4 gap restart", pat, 3*QC + 6, 0);
      for (int b = 2*QC + 2; b < 3*QC + 2; b++) pat[b] = 1'b1;
      episode("R4 gap then full", pat, 3*QC + 10, 0);
    end
    // R6 / R8: press, release, press again, release
    begin
      logic [63:0] pat = '0;
      for (int b = 0; b < QC + 1; b++) pat[b] = 1'b1;
      for (int b = QC + 4; b < 2*QC + 7; b++) pat[b] = 1'b1;
      episode("R6 R8 repeat press", pat, 3*QC + 12, 0);
    end
    // R9: progress made before reset is discarded
    episode("R9 reset mid-run", {64{1'b1}}, QC + 8, QC + 1);
    // R2: toggling input faster than window never sets
    episode("R2 R5 toggle", 64'hAAAA_AAAA_AAAA_AAAA, 20, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule